// File: doc/BRIEF.md
# Interrupt Priority and Service Tracker

This block is the priority core of an eight-input interrupt controller. It samples eight request lines into a pending-request register. A request is taken either on a rising edge or by following the line level. The block filters the pending requests through a mask supplied from outside, and compares the best surviving request with the set of inputs already being serviced. When that request outranks every in-service input, it raises a single request line toward the processor.

When the processor returns a one-cycle acknowledge strobe, the block moves the winning request from the pending register to the in-service register. One cycle later it presents an 8-bit vector, formed from a programmed 5-bit base and the 3-bit input index. End-of-interrupt commands arrive as a one-cycle strobe with a 3-bit command code and a 3-bit level. They clear in-service bits and can rotate the priority order. An automatic end-of-interrupt mode and a special mask mode change how in-service bits are recorded and how they block requests. Register programming, cascading and the bus cycle are handled by neighbouring logic.

Top module: `irq_prio_core`

## Requirements
- R1: With `levelMode` low, a pending bit is set at the first clock edge that sees its line rise. It stays set until acknowledged. A line held high after its acknowledge does not set the bit again.
- R2: With `levelMode` high, each pending bit copies its line at every clock edge. If the only request drops before `intAck`, the acknowledge returns vector `{vecBase, 3'd7}` and leaves `isrOut` unchanged.
- R3: A pending input whose `maskReg` bit is 1 neither raises `intReq` nor wins an acknowledge. A 0 bit lets it through.
- R4: After reset, input 0 has the highest priority and input 7 the lowest. `intReq` is high exactly when some unmasked pending bit ranks strictly above every set in-service bit.
- R5: At an edge with `intAck` high, the winning pending bit clears and its in-service bit sets. After that edge, `vecValid` is high for one cycle and `vecOut` holds `{vecBase, index}`. `vecOut` keeps its value until the next acknowledge.
- R6: The `eoiCmd` code 3'b001 clears the highest-ranked set in-service bit. The code 3'b011 clears the in-service bit named by `eoiLevel`.
- R7: The code 3'b111 clears the bit named by `eoiLevel` and makes that level the lowest priority. The code 3'b101 does the same for the highest-ranked set in-service bit. The code 3'b110 makes `eoiLevel` lowest without touching the in-service bits. The codes 3'b000, 3'b010 and 3'b100 have no effect.
- R8: With `autoEoi` high, an acknowledge still clears the pending bit and returns the vector, but sets no in-service bit.
- R9: With `specialMask` high, a set in-service bit whose mask bit is also set does not block lower-priority requests.
- R10: During and right after reset, `intReq`, `vecValid`, `vecOut`, `irrOut` and `isrOut` are all zero, and the priority order is the default one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 8 | Raw request lines |
| levelMode | input | 1 | 1 = level capture, 0 = rising-edge capture |
| maskReg | input | 8 | Per-input mask, 1 blocks the input |
| vecBase | input | 5 | Upper five bits of every returned vector |
| autoEoi | input | 1 | 1 = no in-service bit is recorded on acknowledge |
| specialMask | input | 1 | 1 = masked in-service bits do not block |
| intAck | input | 1 | One-cycle acknowledge strobe from the processor |
| eoiValid | input | 1 | One-cycle end-of-interrupt command strobe |
| eoiCmd | input | 3 | End-of-interrupt command code |
| eoiLevel | input | 3 | Level named by specific or priority commands |
| intReq | output | 1 | Interrupt request to the processor |
| vecOut | output | 8 | Vector of the last acknowledge |
| vecValid | output | 1 | High for the cycle after an acknowledge |
| irrOut | output | 8 | Pending-request register |
| isrOut | output | 8 | In-service register |

## Verification
The bench holds a line high through its acknowledge and end-of-interrupt. A design that re-armed edge capture from the level would then raise a second request. It also drops a level-mode request before the acknowledge. A design without the spurious path would return a stale index or set an in-service bit. After rotation commands, the bench checks that a request from a numerically lower input is held off by a higher-ranked in-service input. A design with fixed priority would nest wrongly there. It also switches special mask mode on and off over one masked in-service bit, and issues the undefined command codes. Errors in those areas show up as a wrong `intReq` or a changed `isrOut`.

// File: rtl/irq_core_pkg.sv
package irq_core_pkg;
  localparam int NUM_IN = 8;
  localparam int CMD_W = 3;

  // command codes that carry meaning; every other code is a no-op
  localparam logic [CMD_W-1:0] CMD_CLR_TOP = 3'b001;
  localparam logic [CMD_W-1:0] CMD_CLR_NAMED = 3'b011;
  localparam logic [CMD_W-1:0] CMD_ROT_TOP = 3'b101;
  localparam logic [CMD_W-1:0] CMD_ROT_NAMED = 3'b111;
  localparam logic [CMD_W-1:0] CMD_SET_LOW = 3'b110;

  typedef struct packed {
    logic doAck;     // acknowledge this cycle
    logic clrTop;    // clear highest-ranked in-service bit
    logic clrNamed;  // clear in-service bit at eoiLevel
    logic rotTop;    // make the cleared top level the lowest
    logic rotNamed;  // make eoiLevel the lowest
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_core_pkg::*;
(
  input  logic             intAck,
  input  logic             eoiValid,
  input  logic [CMD_W-1:0] eoiCmd,
  output ctrlStrobe_t      strobe
);
  always_comb begin
    strobe = '0;
    strobe.doAck = intAck;
    if (eoiValid) begin
      case (eoiCmd)
        CMD_CLR_TOP:   strobe.clrTop = 1'b1;
        CMD_CLR_NAMED: strobe.clrNamed = 1'b1;
        CMD_ROT_TOP: begin
          strobe.clrTop = 1'b1;
          strobe.rotTop = 1'b1;
        end
        CMD_ROT_NAMED: begin
          strobe.clrNamed = 1'b1;
          strobe.rotNamed = 1'b1;
        end
        CMD_SET_LOW:   strobe.rotNamed = 1'b1;
        default:       strobe = strobe;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_dp.sv
module irq_prio_dp
  import irq_core_pkg::*;
#(
  parameter int NUM = NUM_IN,
  parameter int VEC_W = 8,
  localparam int IDX_W = $clog2(NUM),
  localparam int BASE_W = VEC_W - IDX_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM-1:0]    irqLines,
  input  logic              levelMode,
  input  logic [NUM-1:0]    maskReg,
  input  logic [BASE_W-1:0] vecBase,
  input  logic              autoEoi,
  input  logic              specialMask,
  input  logic [IDX_W-1:0]  eoiLevel,
  input  ctrlStrobe_t       strobe,
  output logic              intReq,
  output logic [VEC_W-1:0]  vecOut,
  output logic              vecValid,
  output logic [NUM-1:0]    irrOut,
  output logic [NUM-1:0]    isrOut
);
  localparam logic [IDX_W-1:0] SPUR_IDX = IDX_W'(NUM - 1);

  logic [NUM-1:0]   irrQ, isrQ, prevQ, irrNext, isrNext;
  logic [NUM-1:0]   eligible, blocking;
  logic [IDX_W-1:0] lowQ, lowNext, scanIdx, reqIdx, topIdx;
  logic             reqFound, topFound, blocked, ackHit;
  logic [VEC_W-1:0] vecQ;
  logic             vldQ;

  // walk inputs from highest to lowest rank under the current rotation
  always_comb begin
    eligible = irrQ & ~maskReg;
    blocking = specialMask ? (isrQ & ~maskReg) : isrQ;
    reqFound = 1'b0;
    reqIdx = '0;
    topFound = 1'b0;
    topIdx = '0;
    blocked = 1'b0;
    scanIdx = '0;
    for (int k = 0; k < NUM; k++) begin
      scanIdx = IDX_W'(int'(lowQ) + 1 + k);
      if (!topFound && isrQ[scanIdx]) begin
        topFound = 1'b1;
        topIdx = scanIdx;
      end
      if (blocking[scanIdx]) blocked = 1'b1;
      if (!blocked && !reqFound && eligible[scanIdx]) begin
        reqFound = 1'b1;
        reqIdx = scanIdx;
      end
    end
  end

  always_comb begin
    ackHit = strobe.doAck && reqFound;
    irrNext = levelMode ? irqLines : (irrQ | (irqLines & ~prevQ));
    if (ackHit) irrNext[reqIdx] = 1'b0;
    isrNext = isrQ;
    if (strobe.clrTop && topFound) isrNext[topIdx] = 1'b0;
    if (strobe.clrNamed) isrNext[eoiLevel] = 1'b0;
    if (ackHit && !autoEoi) isrNext[reqIdx] = 1'b1;
    lowNext = lowQ;
    if (strobe.rotTop && topFound) lowNext = topIdx;
    if (strobe.rotNamed) lowNext = eoiLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irrQ <= '0;
      isrQ <= '0;
      prevQ <= '0;
      lowQ <= SPUR_IDX;
      vecQ <= '0;
      vldQ <= 1'b0;
    end else begin
      irrQ <= irrNext;
      isrQ <= isrNext;
      prevQ <= irqLines;
      lowQ <= lowNext;
      vldQ <= strobe.doAck;
      if (strobe.doAck) vecQ <= {vecBase, (reqFound ? reqIdx : SPUR_IDX)};
    end
  end

  assign intReq = reqFound;
  assign vecOut = vecQ;
  assign vecValid = vldQ;
  assign irrOut = irrQ;
  assign isrOut = isrQ;
endmodule

// File: rtl/irq_prio_core.sv
module irq_prio_core
  import irq_core_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] irqLines,
  input  logic       levelMode,
  input  logic [7:0] maskReg,
  input  logic [4:0] vecBase,
  input  logic       autoEoi,
  input  logic       specialMask,
  input  logic       intAck,
  input  logic       eoiValid,
  input  logic [2:0] eoiCmd,
  input  logic [2:0] eoiLevel,
  output logic       intReq,
  output logic [7:0] vecOut,
  output logic       vecValid,
  output logic [7:0] irrOut,
  output logic [7:0] isrOut
);
  ctrlStrobe_t strobe;

  irq_prio_ctrl u_ctrl (
    .intAck(intAck),
    .eoiValid(eoiValid),
    .eoiCmd(eoiCmd),
    .strobe(strobe)
  );

  irq_prio_dp #(.NUM(8), .VEC_W(8)) u_dp (
    .clk(clk),
    .rstN(rstN),
    .irqLines(irqLines),
    .levelMode(levelMode),
    .maskReg(maskReg),
    .vecBase(vecBase),
    .autoEoi(autoEoi),
    .specialMask(specialMask),
    .eoiLevel(eoiLevel),
    .strobe(strobe),
    .intReq(intReq),
    .vecOut(vecOut),
    .vecValid(vecValid),
    .irrOut(irrOut),
    .isrOut(isrOut)
  );
endmodule

// File: rtl/irq_prio_core_chk.sv
module irq_prio_core_chk (
  input logic       clk,
  input logic       rstN,
  input logic       intAck,
  input logic       eoiValid,
  input logic       autoEoi,
  input logic [7:0] maskReg,
  input logic [4:0] vecBase,
  input logic       intReq,
  input logic [7:0] vecOut,
  input logic       vecValid,
  input logic [7:0] irrOut,
  input logic [7:0] isrOut
);
  // R5
  ack_gives_vec_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> vecValid);

  // R5
  vec_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && $stable(vecBase)) |=> (vecOut[7:3] == vecBase));

  // R5
  one_isr_per_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    intAck |=> $onehot0(isrOut & ~$past(isrOut)));

  // R3
  mask_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> ((irrOut & ~maskReg) != 8'h00));

  // R3
  masked_no_service_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !eoiValid) |=> (((isrOut & ~$past(isrOut)) & $past(maskReg)) == 8'h00));

  // R8
  auto_eoi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && autoEoi && !eoiValid) |=> $stable(isrOut));

  // R2
  spurious_isr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !eoiValid && ((irrOut & ~maskReg) == 8'h00)) |=> $stable(isrOut));
endmodule

bind irq_prio_core irq_prio_core_chk u_chk (
  .clk(clk),
  .rstN(rstN),
  .intAck(intAck),
  .eoiValid(eoiValid),
  .autoEoi(autoEoi),
  .maskReg(maskReg),
  .vecBase(vecBase),
  .intReq(intReq),
  .vecOut(vecOut),
  .vecValid(vecValid),
  .irrOut(irrOut),
  .isrOut(isrOut)
);

// File: tb/tb_irq_prio_core.sv
`timescale 1ns/1ps
module tb_irq_prio_core;
  logic clk = 1'b0;
  logic rstN;
  logic [7:0] irqLines, maskReg;
  logic levelMode, autoEoi, specialMask, intAck, eoiValid;
  logic [4:0] vecBase;
  logic [2:0] eoiCmd, eoiLevel;
  logic intReq, vecValid;
  logic [7:0] vecOut, irrOut, isrOut;
  int checkCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_prio_core dut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .levelMode(levelMode),
    .maskReg(maskReg), .vecBase(vecBase), .autoEoi(autoEoi),
    .specialMask(specialMask), .intAck(intAck), .eoiValid(eoiValid),
    .eoiCmd(eoiCmd), .eoiLevel(eoiLevel), .intReq(intReq), .vecOut(vecOut),
    .vecValid(vecValid), .irrOut(irrOut), .isrOut(isrOut)
  );

  typedef struct packed {
    logic [7:0] lines;
    logic [7:0] mask;
    logic       ack;
    logic       eoiV;
    logic [2:0] cmd;
    logic [2:0] lvl;
    logic       expReq;
    logic [7:0] expIsr;
    logic       expVv;
    logic [7:0] expVec;
  } row_t;

  // edge mode, vecBase = 5'b01000; each row is applied, one edge passes, then checked
  localparam row_t TBL [0:15] = '{
    '{8'h08, 8'h00, 1'b0, 1'b0, 3'b000, 3'd0, 1'b1, 8'h00, 1'b0, 8'h00}, // R1 rise on input 3
    '{8'h08, 8'h00, 1'b1, 1'b0, 3'b000, 3'd0, 1'b0, 8'h08, 1'b1, 8'h43}, // R5 ack input 3
    '{8'h88, 8'h00, 1'b0, 1'b0, 3'b000, 3'd0, 1'b0, 8'h08, 1'b0, 8'h43}, // R4 input 7 below 3
    '{8'h89, 8'h00, 1'b0, 1'b0, 3'b000, 3'd0, 1'b1, 8'h08, 1'b0, 8'h43}, // R4 input 0 nests
    '{8'h89, 8'h00, 1'b1, 1'b0, 3'b000, 3'd0, 1'b0, 8'h09, 1'b1, 8'h40}, // R5 ack input 0
    '{8'h89, 8'h00, 1'b0, 1'b1, 3'b001, 3'd0, 1'b0, 8'h08, 1'b0, 8'h40}, // R6 clear top
    '{8'h89, 8'h00, 1'b0, 1'b1, 3'b011, 3'd3, 1'b1, 8'h00, 1'b0, 8'h40}, // R6 clear named 3
    '{8'h89, 8'h80, 1'b0, 1'b0, 3'b000, 3'd0, 1'b0, 8'h00, 1'b0, 8'h40}, // R3 mask input 7
    '{8'h89, 8'h00, 1'b1, 1'b0, 3'b000, 3'd0, 1'b0, 8'h80, 1'b1, 8'h47}, // R3 unmask, ack 7
    '{8'h89, 8'h00, 1'b0, 1'b1, 3'b111, 3'd7, 1'b0, 8'h00, 1'b0, 8'h47}, // R7 rotate named 7
    '{8'h00, 8'h00, 1'b0, 1'b1, 3'b110, 3'd3, 1'b0, 8'h00, 1'b0, 8'h47}, // R7 set lowest 3
    '{8'h11, 8'h00, 1'b0, 1'b0, 3'b000, 3'd0, 1'b1, 8'h00, 1'b0, 8'h47}, // R1 rises on 0 and 4
    '{8'h11, 8'h00, 1'b1, 1'b0, 3'b000, 3'd0, 1'b0, 8'h10, 1'b1, 8'h44}, // R7 input 4 now wins
    '{8'h11, 8'h00, 1'b0, 1'b1, 3'b111, 3'd4, 1'b1, 8'h00, 1'b0, 8'h44}, // R7 rotate named 4
    '{8'h11, 8'h00, 1'b1, 1'b0, 3'b000, 3'd0, 1'b0, 8'h01, 1'b1, 8'h40}, // R5 ack input 0
    '{8'h11, 8'h00, 1'b0, 1'b1, 3'b101, 3'd0, 1'b0, 8'h00, 1'b0, 8'h40}  // R7 rotate top
  };

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    intAck = 1'b0;
    eoiValid = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    irqLines = '0; maskReg = '0; levelMode = 1'b0; autoEoi = 1'b0;
    specialMask = 1'b0; intAck = 1'b0; eoiValid = 1'b0; eoiCmd = '0;
    eoiLevel = '0; vecBase = 5'b01000;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      finishRun();
    end
  end

  initial begin
    doReset();
    // R10 reset state
    check("R10", "intReq", intReq, 0);
    check("R10", "vecValid", vecValid, 0);
    check("R10", "vecOut", vecOut, 0);
    check("R10", "irrOut", irrOut, 0);
    check("R10", "isrOut", isrOut, 0);

    for (int i = 0; i < 16; i++) begin
      irqLines = TBL[i].lines;
      maskReg = TBL[i].mask;
      intAck = TBL[i].ack;
      eoiValid = TBL[i].eoiV;
      eoiCmd = TBL[i].cmd;
      eoiLevel = TBL[i].lvl;
      step();
      check("R4", "intReq", intReq, TBL[i].expReq);
      check("R6", "isrOut", isrOut, TBL[i].expIsr);
      check("R5", "vecValid", vecValid, TBL[i].expVv);
      check("R5", "vecOut", vecOut, TBL[i].expVec);
    end

    // R2 level request withdrawn before acknowledge
    doReset();
    levelMode = 1'b1;
    irqLines = 8'h04; step();
    check("R2", "intReq", intReq, 1);
    irqLines = 8'h00; step();
    check("R2", "irrOut", irrOut, 0);
    intAck = 1'b1; step();
    check("R2", "vecValid", vecValid, 1);
    check("R2", "vecOut", vecOut, 8'h47);
    check("R2", "isrOut", isrOut, 0);

    // R1 held line does not re-arm in edge mode
    doReset();
    irqLines = 8'h02; step();
    intAck = 1'b1; step();
    check("R1", "isrOut", isrOut, 8'h02);
    eoiValid = 1'b1; eoiCmd = 3'b001; step();
    step();
    check("R1", "irrOut", irrOut, 0);
    check("R1", "intReq", intReq, 0);
    // R2 level mode picks the held line up again
    levelMode = 1'b1; step();
    check("R2", "irrOut", irrOut, 8'h02);
    check("R2", "intReq", intReq, 1);

    // R8 automatic end of interrupt
    doReset();
    autoEoi = 1'b1;
    irqLines = 8'h20; step();
    intAck = 1'b1; step();
    check("R8", "vecOut", vecOut, 8'h45);
    check("R8", "isrOut", isrOut, 0);
    check("R8", "irrOut", irrOut, 0);

    // R9 special mask mode
    doReset();
    irqLines = 8'h02; step();
    intAck = 1'b1; step();
    irqLines = 8'h22; step();
    check("R9", "intReq blocked", intReq, 0);
    maskReg = 8'h02; specialMask = 1'b1; step();
    check("R9", "intReq special", intReq, 1);
    specialMask = 1'b0; step();
    check("R9", "intReq normal", intReq, 0);

    // R7 undefined command codes leave state alone
    eoiValid = 1'b1; eoiCmd = 3'b000; eoiLevel = 3'd1; step();
    check("R7", "isr after 000", isrOut, 8'h02);
    eoiValid = 1'b1; eoiCmd = 3'b010; eoiLevel = 3'd1; step();
    check("R7", "isr after 010", isrOut, 8'h02);
    eoiValid = 1'b1; eoiCmd = 3'b100; eoiLevel = 3'd1; step();
    check("R7", "isr after 100", isrOut, 8'h02);
    check("R7", "irr kept", irrOut, 8'h20);

    done = 1'b1;
    finishRun();
  end
endmodule